// File: doc/BRIEF.md
# Per-Core Interrupt Concentrator

This block collects three classes of interrupt sources inside one cluster and routes them to several cores. The first class is hardware lines from local peripherals. The second is write-triggered mailboxes, held inside the block. The third is timer outputs, which arrive from a separate timer block. Each core owns one enable mask per class. The block raises that core's interrupt line while any source it has enabled is active.

Software reaches the block through a simple register port. The word address has two parts: a 5-bit function code in `reg_addr[9:5]` and a 5-bit index in `reg_addr[4:0]`. The index selects a core for the mask, status and priority functions, and a mailbox for the mailbox function. Each mask can be:
- overwritten;
- OR-ed through an enable alias;
- cleared bit-wise through a disable alias.

A read at the disable alias returns the enabled-and-active status instead of the mask. A priority word gives the lowest-index active source of each class. A configuration word gives the number of sources in each class.

Top module: `irq_concentrator`

## Requirements
- R1: After reset all masks are zero, no mailbox is pending, every mailbox word reads zero and `irq_out` is all zero.
- R2: `irq_out[c]` is combinationally high exactly when core c has at least one enabled source that is active. Active means a high `hwi_in` bit, a pending mailbox or a high `pti_in` bit.
- R3: Function codes 4 (timer), 8 (hardware line) and 12 (mailbox) overwrite the selected core's mask with the low bits of the write data. Reads at these codes, and at the enable codes 5/9/13, return the mask zero-extended to 32 bits.
- R4: A write at enable code 5, 9 or 13 ORs the write data into the mask.
- R5: A write at disable code 6, 10 or 14 clears the mask bits that are set in the data. A read at these codes returns the class's active input AND-ed with the mask.
- R6: A write at code 0 with index i stores the data in mailbox i and makes it pending. A read at code 0 returns the stored word and clears the pending flag in the same access, but keeps the word.
- R7: A read at code 15 returns the core's priority word. Byte 0 covers hardware lines, byte 1 mailboxes and byte 2 timers. Each byte holds bit 7 = valid and bits 4:0 = the lowest enabled active index. The byte is zero when no source of that class is enabled and active.
- R8: A read at code 16, with any index, returns the hardware-line count in byte 0, the mailbox count in byte 1 and the timer count in byte 2.
- R9: Accesses that do not land on a defined register are ignored on write and read as zero. This covers a core index at or above the core count, a mailbox index at or above the mailbox count, undefined codes, and writes at codes 15 and 16.
- R10: Read data appears on `reg_rdata` with `rd_valid` high in the cycle after a read request. `rd_valid` is low after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Function code [9:5], index [4:0] |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| hwi_in | input | N_HWI | Hardware interrupt lines |
| pti_in | input | N_PTI | Timer interrupt lines |
| irq_out | output | N_CORES | Interrupt line per core |

## Verification
The bench builds the block with three cores, sixteen hardware lines, eight mailboxes and four timer inputs. With three cores, index 3 still fits the core-select field but names no core. With eight mailboxes, index 9 does the same for the mailbox field. Both boundaries of R9 are therefore exercised. The unequal class sizes give a configuration word whose three bytes differ, so a swapped lane is visible. Sixteen hardware lines let a full-width write show that bits beyond the mask width are dropped.

// File: rtl/irq_concentrator.sv
module irq_concentrator #(
  parameter int N_CORES = 4,
  parameter int N_HWI   = 16,
  parameter int N_WTI   = 16,
  parameter int N_PTI   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_req,
  input  logic               reg_we,
  input  logic [9:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic               rd_valid,
  output logic [31:0]        reg_rdata,
  input  logic [N_HWI-1:0]   hwi_in,
  input  logic [N_PTI-1:0]   pti_in,
  output logic [N_CORES-1:0] irq_out
);
  localparam int IW = 5;

  logic [IW-1:0] fn, idx;
  logic wr, rd;
  assign fn  = reg_addr[9:5];
  assign idx = reg_addr[4:0];
  assign wr  = reg_req & reg_we;
  assign rd  = reg_req & ~reg_we;

  logic [N_CORES-1:0][N_HWI-1:0] m_hwi, st_h;
  logic [N_CORES-1:0][N_WTI-1:0] m_wti, st_w;
  logic [N_CORES-1:0][N_PTI-1:0] m_pti, st_p;
  logic [N_WTI-1:0]              wti_pend;
  logic [31:0]                   mbox [N_WTI];
  logic [31:0]                   rnext;

  function automatic logic [7:0] first_set(input logic [31:0] v);
    logic [7:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--)
      if (v[i]) r = {3'b100, 5'(i)};
    return r;
  endfunction

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    assign st_h[c]    = hwi_in   & m_hwi[c];
    assign st_w[c]    = wti_pend & m_wti[c];
    assign st_p[c]    = pti_in   & m_pti[c];
    assign irq_out[c] = |{st_h[c], st_w[c], st_p[c]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hwi <= '0;
      m_wti <= '0;
      m_pti <= '0;
    end else if (wr) begin
      for (int c = 0; c < N_CORES; c++) begin
        if (idx == IW'(c)) begin
          case (fn)
            5'd4:  m_pti[c] <= reg_wdata[N_PTI-1:0];
            5'd5:  m_pti[c] <= m_pti[c] | reg_wdata[N_PTI-1:0];
            5'd6:  m_pti[c] <= m_pti[c] & ~reg_wdata[N_PTI-1:0];
            5'd8:  m_hwi[c] <= reg_wdata[N_HWI-1:0];
            5'd9:  m_hwi[c] <= m_hwi[c] | reg_wdata[N_HWI-1:0];
            5'd10: m_hwi[c] <= m_hwi[c] & ~reg_wdata[N_HWI-1:0];
            5'd12: m_wti[c] <= reg_wdata[N_WTI-1:0];
            5'd13: m_wti[c] <= m_wti[c] | reg_wdata[N_WTI-1:0];
            5'd14: m_wti[c] <= m_wti[c] & ~reg_wdata[N_WTI-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wti_pend <= '0;
      for (int w = 0; w < N_WTI; w++) mbox[w] <= '0;
    end else if (reg_req && fn == '0) begin
      for (int w = 0; w < N_WTI; w++) begin
        if (idx == IW'(w)) begin
          if (reg_we) begin
            mbox[w]     <= reg_wdata;
            wti_pend[w] <= 1'b1;
          end else begin
            wti_pend[w] <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    rnext = '0;
    if (fn == 5'd0) begin
      for (int w = 0; w < N_WTI; w++)
        if (idx == IW'(w)) rnext = mbox[w];
    end else if (fn == 5'd16) begin
      rnext = {8'd0, 8'(N_PTI), 8'(N_WTI), 8'(N_HWI)};
    end else begin
      for (int c = 0; c < N_CORES; c++) begin
        if (idx == IW'(c)) begin
          case (fn)
            5'd4, 5'd5:   rnext = 32'(m_pti[c]);
            5'd6:         rnext = 32'(st_p[c]);
            5'd8, 5'd9:   rnext = 32'(m_hwi[c]);
            5'd10:        rnext = 32'(st_h[c]);
            5'd12, 5'd13: rnext = 32'(m_wti[c]);
            5'd14:        rnext = 32'(st_w[c]);
            5'd15:        rnext = {8'd0, first_set(32'(st_p[c])),
                                   first_set(32'(st_w[c])), first_set(32'(st_h[c]))};
            default:      rnext = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) reg_rdata <= rnext;
    end
  end
endmodule

// File: rtl/irq_concentrator_chk.sv
module irq_concentrator_chk #(
  parameter int N_CORES = 4,
  parameter int N_HWI   = 16,
  parameter int N_WTI   = 16,
  parameter int N_PTI   = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_req,
  input logic                          reg_we,
  input logic [9:0]                    reg_addr,
  input logic [N_HWI-1:0]              hw_wdata,
  input logic                          rd_valid,
  input logic [N_CORES-1:0]            irq_out,
  input logic [N_WTI-1:0]              wti_pend,
  input logic [N_CORES-1:0][N_HWI-1:0] m_hwi,
  input logic [N_CORES-1:0][N_WTI-1:0] m_wti,
  input logic [N_CORES-1:0][N_PTI-1:0] m_pti
);
  localparam int CW = (N_CORES > 1) ? $clog2(N_CORES) : 1;
  localparam int WW = (N_WTI > 1) ? $clog2(N_WTI) : 1;

  logic [4:0] fn, idx;
  assign fn  = reg_addr[9:5];
  assign idx = reg_addr[4:0];

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we) |=> rd_valid); // R10

  AST_WR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && !reg_we) |=> !rd_valid); // R10

  AST_MBOX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && fn == 5'd0 && idx < 5'(N_WTI))
      |=> wti_pend[$past(idx[WW-1:0])]); // R6

  AST_MBOX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we && fn == 5'd0 && idx < 5'(N_WTI))
      |=> !wti_pend[$past(idx[WW-1:0])]); // R6

  AST_HWI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && fn == 5'd10 && idx < 5'(N_CORES))
      |=> (m_hwi[$past(idx[CW-1:0])] & $past(hw_wdata)) == '0); // R5

  for (genvar c = 0; c < N_CORES; c++) begin : g_q
    AST_QUIET_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (m_hwi[c] == '0 && m_wti[c] == '0 && m_pti[c] == '0) |-> !irq_out[c]); // R2
  end
endmodule

bind irq_concentrator irq_concentrator_chk #(
  .N_CORES(N_CORES), .N_HWI(N_HWI), .N_WTI(N_WTI), .N_PTI(N_PTI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .hw_wdata(reg_wdata[N_HWI-1:0]), .rd_valid(rd_valid),
  .irq_out(irq_out), .wti_pend(wti_pend), .m_hwi(m_hwi), .m_wti(m_wti),
  .m_pti(m_pti)
);

// File: tb/irq_concentrator_tb.sv
`timescale 1ns/1ps
module irq_concentrator_tb;
  localparam int NC = 3, NH = 16, NW = 8, NP = 4;

  logic clk = 0, rst_n = 0;
  logic reg_req = 0, reg_we = 0;
  logic [9:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic rd_valid;
  logic [31:0] reg_rdata;
  logic [NH-1:0] hwi_in = '0;
  logic [NP-1:0] pti_in = '0;
  logic [NC-1:0] irq_out;

  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  irq_concentrator #(.N_CORES(NC), .N_HWI(NH), .N_WTI(NW), .N_PTI(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_valid(rd_valid),
    .reg_rdata(reg_rdata), .hwi_in(hwi_in), .pti_in(pti_in), .irq_out(irq_out));

  function automatic logic [9:0] ad(input int f, input int i);
    return {5'(f), 5'(i)};
  endfunction

  task automatic wr(input int f, input int i, input logic [31:0] d);
    reg_req = 1; reg_we = 1; reg_addr = ad(f, i); reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic rd(input int f, input int i, input logic [31:0] e, input string t);
    reg_req = 1; reg_we = 0; reg_addr = ad(f, i);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_req = 0;
  endtask

  task automatic chk_irq(input logic [NC-1:0] e, input string t);
    #1;
    tests++;
    if (irq_out !== e) begin
      fails++;
      $display("FAIL %s irq_out actual=%b expected=%b", t, irq_out, e);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && rd_valid) begin
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R10 unexpected read data actual=%h expected=none", reg_rdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (reg_rdata !== e) begin
            fails++;
            $display("FAIL %s rdata actual=%h expected=%h", t, reg_rdata, e);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_irq(3'b000, "R1 reset irq");
    rd(8, 0, 32'h0, "R1 reset hwi mask");
    rd(0, 2, 32'h0, "R1 reset mailbox");
    rd(16, 0, 32'h0004_0810, "R8 config");
    rd(16, 2, 32'h0004_0810, "R8 config other index");

    wr(8, 1, 32'h0000_00F0);
    rd(8, 1, 32'h0000_00F0, "R3 full write readback");
    rd(9, 1, 32'h0000_00F0, "R3 read at enable code");
    wr(9, 1, 32'h0000_0003);
    rd(8, 1, 32'h0000_00F3, "R4 enable OR");
    wr(10, 1, 32'h0000_0021);
    tests++;
    if (rd_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 rd_valid after write actual=%b expected=0", rd_valid);
    end
    rd(8, 1, 32'h0000_00D2, "R5 disable clear");
    wr(8, 1, 32'hFFFF_0001);
    rd(8, 1, 32'h0000_0001, "R3 width truncation");
    wr(8, 1, 32'h0000_00D2);

    chk_irq(3'b000, "R2 no active");
    hwi_in = 16'h0100;
    chk_irq(3'b000, "R2 active but masked");
    hwi_in = 16'h0050;
    chk_irq(3'b010, "R2 hwi enabled");
    rd(10, 1, 32'h0000_0050, "R5 status at disable code");
    rd(15, 1, 32'h0000_0084, "R7 hwi winner");
    rd(15, 0, 32'h0000_0000, "R7 no valid");

    wr(12, 2, 32'h0000_000C);
    wr(0, 3, 32'hCAFE_0003);
    chk_irq(3'b110, "R6 mailbox raises irq");
    rd(14, 2, 32'h0000_0008, "R5 wti status");
    wr(0, 5, 32'h0000_0055);
    rd(15, 2, 32'h0000_8300, "R7 wti winner");
    rd(0, 3, 32'hCAFE_0003, "R6 mailbox read");
    chk_irq(3'b010, "R6 read clears pending");
    rd(0, 3, 32'hCAFE_0003, "R6 word kept");
    rd(14, 2, 32'h0000_0000, "R6 pending cleared");

    wr(4, 0, 32'h0000_000F);
    wr(6, 0, 32'h0000_0001);
    pti_in = 4'h5;
    chk_irq(3'b011, "R2 pti enabled");
    rd(6, 0, 32'h0000_0004, "R5 pti status");
    wr(8, 0, 32'h0000_000C);
    hwi_in = 16'h0058;
    rd(15, 0, 32'h0082_0083, "R7 hwi and pti lanes");
    rd(15, 1, 32'h0000_0084, "R7 lowest index wins");
    wr(13, 2, 32'h0000_0020);
    rd(15, 2, 32'h0000_8500, "R7 wti index 5");
    wr(0, 2, 32'h0000_0002);
    rd(15, 2, 32'h0000_8200, "R7 lower mailbox wins");
    chk_irq(3'b111, "R2 all cores");

    wr(8, 3, 32'h0000_FFFF);
    rd(8, 3, 32'h0, "R9 absent core reads zero");
    chk_irq(3'b111, "R9 absent core write no effect");
    wr(0, 9, 32'h0000_1234);
    rd(0, 9, 32'h0, "R9 absent mailbox");
    rd(20, 0, 32'h0, "R9 undefined code");
    wr(7, 0, 32'h0000_FFFF);
    rd(4, 0, 32'h0000_000E, "R9 undefined code write ignored");
    wr(15, 0, 32'h0);
    rd(15, 0, 32'h0082_0083, "R9 priority not writable");
    wr(12, 0, 32'h0000_0200);
    rd(12, 0, 32'h0, "R9 bits above mailbox count dropped");

    repeat (3) @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing read responses actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule